// File: doc/BRIEF.md
# Delayed Transaction Target Controller

This block is the target side of a shared request/response bus whose backend is slow. A master presents a request and holds it until it gets a one-cycle acknowledge or a one-cycle retry. The controller counts the cycles since the request was sampled. If the backend cannot finish before the latency limit, the controller answers with a retry, keeps the request in a single pending slot and runs it against the backend without the master. When the master comes back with exactly the same request, it gets the read data, or for a write the completion, on the first cycle. Posted writes go into a small queue. They are acknowledged at once, even while a request is pending. Every posted write accepted before a pending request reaches the backend ahead of it.

The main state machine has four states. IDLE decodes a new request. SERVE waits on the backend while the master is present. ACK and RETRY each drive a one-cycle response. The transitions are:
- IDLE->SERVE (latch): a non-posted request while the slot is empty.
- IDLE->ACK (post): a posted write with queue room.
- IDLE->ACK (claim): a matching request whose completion is ready.
- IDLE->RETRY (busy): a full queue, a mismatch, or a match not yet complete.
- SERVE->ACK (done): the backend finished.
- SERVE->RETRY (timeout): the limit was reached with delayed mode on.
- ACK->IDLE and RETRY->IDLE: the response is over.

The backend port has three states. BP_IDLE picks the next job. BP_POST drains the queue head and pops it on acknowledge. BP_DELAYED sends the pending request and leaves when it is done.

Top module: `dtc_target`

## Requirements
- R1: After reset, rsp_ack, rsp_retry, be_req and discard_flag are all low.
- R2: A read (req_cmd 2'b00, or 2'b11, which is treated as a read) that the backend finishes before the limit is acknowledged without a retry, with rsp_rdata equal to the backend's read data.
- R3: With cfg_host_bridge low and cfg_delay_en high, a request that the backend has not finished gets rsp_retry on the 16th rising edge, counting the edge that first samples it.
- R4: With cfg_host_bridge high, that retry comes on the 32nd rising edge instead.
- R5: After a retry, the backend operation runs without the master. A reissue with equal req_cmd, req_addr and req_be, made after it finishes, is acknowledged on the first edge with the read data.
- R6: A matching reissue made before the backend finishes is retried on the first edge.
- R7: A non-posted write (req_cmd 2'b01) that times out is retried. The backend then writes the latched address, data and byte enables. A matching reissue is acknowledged with rsp_rdata zero.
- R8: Only one request is held. A non-posted request that differs in command, address or byte enables from the pending one is retried on the first edge and never reaches the backend.
- R9: A posted write (req_cmd 2'b10) is acknowledged on the first edge, also while a request is pending. When the queue already holds POST_DEPTH writes, it is retried and dropped.
- R10: Posted writes accepted before a request was latched are written to the backend before that request is issued, so before its completion is returned. Later posted writes follow it.
- R11: A completion left unclaimed for DISCARD_CYCLES cycles is dropped and discard_flag is set until reset. A later reissue is handled as a new request.
- R12: With cfg_delay_en low, no request is retried for latency. The master waits until the backend finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_delay_en | input | 1 | Enables latency retry and delayed completion |
| cfg_host_bridge | input | 1 | Selects the longer first-phase limit |
| req_valid | input | 1 | Request present; held until a response |
| req_cmd | input | 2 | 00 read, 01 non-posted write, 10 posted write, 11 read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables |
| rsp_ack | output | 1 | One-cycle completion |
| rsp_retry | output | 1 | One-cycle retry termination |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_ack |
| be_req | output | 1 | Backend request, held until be_ack |
| be_we | output | 1 | Backend write |
| be_addr | output | ADDR_W | Backend address |
| be_wdata | output | DATA_W | Backend write data |
| be_be | output | DATA_W/8 | Backend byte enables |
| be_ack | input | 1 | Backend done, one cycle |
| be_rdata | input | DATA_W | Backend read data, valid with be_ack |
| discard_flag | output | 1 | Sticky: an unclaimed completion was dropped |

## Verification
Most faults in the pending slot show up on the next reissue. A slot that was not cleared, or that was latched twice, leads to a retry where an acknowledge was due, or to an extra backend operation, and both are seen within one or two cycles of the reissue. A wrong latency count moves the retry away from edge 16 or 32 and is seen at once. A wrong queue-ahead count shows up as a reordered backend operation, at the moment the pending request is issued. A broken discard timer is seen only after the full timeout, as a flag or a fresh backend operation that should not be there.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;

    localparam logic [1:0] CMD_READ       = 2'b00;
    localparam logic [1:0] CMD_WRITE_NP   = 2'b01;
    localparam logic [1:0] CMD_WRITE_POST = 2'b10;

    typedef enum logic [1:0] {
        TS_IDLE,
        TS_SERVE,
        TS_ACK,
        TS_RETRY
    } tgt_state_e;

    typedef enum logic [1:0] {
        BP_IDLE,
        BP_POST,
        BP_DELAYED
    } bp_state_e;

    function automatic logic cmd_is_posted(input logic [1:0] cmd);
        return cmd == CMD_WRITE_POST;
    endfunction

    function automatic logic cmd_is_np_write(input logic [1:0] cmd);
        return cmd == CMD_WRITE_NP;
    endfunction

endpackage

// File: rtl/dtc_post_fifo.sv
`timescale 1ns/1ps
module dtc_post_fifo #(
    parameter int WIDTH = 68,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/dtc_backend_port.sv
`timescale 1ns/1ps
module dtc_backend_port
    import dtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    input  logic [BE_W-1:0]   head_be,
    input  logic              dr_latch,
    input  logic              dr_valid,
    input  logic              dr_is_write,
    input  logic [ADDR_W-1:0] dr_addr,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic [BE_W-1:0]   dr_be,
    input  logic              be_ack,
    output logic              fifo_pop,
    output logic              dr_done_pulse,
    output logic              dr_issue,
    output logic              ahead_zero,
    output logic              be_req,
    output logic              be_we,
    output logic [ADDR_W-1:0] be_addr,
    output logic [DATA_W-1:0] be_wdata,
    output logic [BE_W-1:0]   be_be
);

    bp_state_e        bp_state, bp_next;
    logic [CNT_W-1:0] ahead;
    logic             dr_sent;

    always_comb begin
        bp_next = bp_state;
        unique case (bp_state)
            BP_IDLE: begin
                if (dr_valid && !dr_sent && ahead == '0) begin
                    bp_next = BP_DELAYED;
                end else if (!fifo_empty) begin
                    bp_next = BP_POST;
                end
            end
            BP_POST:    if (be_ack) bp_next = BP_IDLE;
            BP_DELAYED: if (be_ack) bp_next = BP_IDLE;
            default:    bp_next = BP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_state <= BP_IDLE;
            ahead    <= '0;
            dr_sent  <= 1'b0;
        end else begin
            bp_state <= bp_next;
            if (dr_latch) begin
                ahead <= fifo_count - CNT_W'(fifo_pop);
            end else if (fifo_pop && ahead != '0) begin
                ahead <= ahead - CNT_W'(1);
            end
            if (dr_latch) begin
                dr_sent <= 1'b0;
            end else if (bp_state == BP_IDLE && bp_next == BP_DELAYED) begin
                dr_sent <= 1'b1;
            end
        end
    end

    always_comb begin
        be_req        = (bp_state != BP_IDLE);
        dr_issue      = (bp_state == BP_DELAYED);
        fifo_pop      = (bp_state == BP_POST) && be_ack;
        dr_done_pulse = (bp_state == BP_DELAYED) && be_ack;
        ahead_zero    = (ahead == '0);
        if (bp_state == BP_DELAYED) begin
            be_we    = dr_is_write;
            be_addr  = dr_addr;
            be_wdata = dr_wdata;
            be_be    = dr_be;
        end else begin
            be_we    = 1'b1;
            be_addr  = head_addr;
            be_wdata = head_data;
            be_be    = head_be;
        end
    end

endmodule

// File: rtl/dtc_claim_timer.sv
`timescale 1ns/1ps
module dtc_claim_timer #(
    parameter int LIMIT = 32768,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    logic [CNT_W-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (!run) begin
            held <= '0;
        end else if (held != CNT_W'(LIMIT)) begin
            held <= held + CNT_W'(1);
        end
    end

    assign expire = run && (held == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/dtc_target.sv
`timescale 1ns/1ps
module dtc_target
    import dtc_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int POST_DEPTH     = 4,
    parameter int FIRST_LIMIT    = 16,
    parameter int HOST_LIMIT     = 32,
    parameter int DISCARD_CYCLES = 32768,
    localparam int BE_W          = DATA_W / 8,
    localparam int LAT_W         = $clog2(HOST_LIMIT + 1),
    localparam int CNT_W         = $clog2(POST_DEPTH + 1),
    localparam int ENTRY_W       = ADDR_W + DATA_W + BE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_delay_en,
    input  logic              cfg_host_bridge,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              rsp_ack,
    output logic              rsp_retry,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              be_req,
    output logic              be_we,
    output logic [ADDR_W-1:0] be_addr,
    output logic [DATA_W-1:0] be_wdata,
    output logic [BE_W-1:0]   be_be,
    input  logic              be_ack,
    input  logic [DATA_W-1:0] be_rdata,
    output logic              discard_flag
);

    tgt_state_e        state, state_nx;
    logic [LAT_W-1:0]  lat_cnt;
    logic [LAT_W-1:0]  lat_limit;
    logic              dr_valid, dr_done;
    logic [1:0]        dr_cmd;
    logic [ADDR_W-1:0] dr_addr;
    logic [DATA_W-1:0] dr_wdata, dr_rdata, rdata_q;
    logic [BE_W-1:0]   dr_be;
    logic              discard_q;

    logic              do_push, do_latch, do_claim;
    logic              dr_match, serve_st;
    logic              fifo_pop, fifo_empty, fifo_full;
    logic [CNT_W-1:0]  fifo_count;
    logic [ENTRY_W-1:0] fifo_head;
    logic              dr_done_pulse, dr_issue, ahead_zero;
    logic              discard_expire;

    assign serve_st  = (state == TS_SERVE);
    assign lat_limit = cfg_host_bridge ? LAT_W'(HOST_LIMIT - 1) : LAT_W'(FIRST_LIMIT - 1);
    assign dr_match  = dr_valid && (req_cmd == dr_cmd) &&
                       (req_addr == dr_addr) && (req_be == dr_be);

    // next-state and action decode
    always_comb begin
        state_nx = state;
        do_push  = 1'b0;
        do_latch = 1'b0;
        do_claim = 1'b0;
        unique case (state)
            TS_IDLE: begin
                if (req_valid) begin
                    if (cmd_is_posted(req_cmd)) begin
                        if (!fifo_full) begin
                            do_push  = 1'b1;
                            state_nx = TS_ACK;
                        end else begin
                            state_nx = TS_RETRY;
                        end
                    end else if (dr_valid) begin
                        if (dr_match && dr_done) begin
                            do_claim = 1'b1;
                            state_nx = TS_ACK;
                        end else begin
                            state_nx = TS_RETRY;
                        end
                    end else begin
                        do_latch = 1'b1;
                        state_nx = TS_SERVE;
                    end
                end
            end
            TS_SERVE: begin
                if (dr_done) begin
                    do_claim = 1'b1;
                    state_nx = TS_ACK;
                end else if (cfg_delay_en && lat_cnt >= lat_limit) begin
                    state_nx = TS_RETRY;
                end
            end
            TS_ACK:   state_nx = TS_IDLE;
            TS_RETRY: state_nx = TS_IDLE;
            default:  state_nx = TS_IDLE;
        endcase
    end

    // state register and pending-slot storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= TS_IDLE;
            lat_cnt   <= '0;
            dr_valid  <= 1'b0;
            dr_done   <= 1'b0;
            dr_cmd    <= CMD_READ;
            dr_addr   <= '0;
            dr_wdata  <= '0;
            dr_be     <= '0;
            dr_rdata  <= '0;
            rdata_q   <= '0;
            discard_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (do_latch) begin
                dr_valid <= 1'b1;
                dr_done  <= 1'b0;
                dr_cmd   <= req_cmd;
                dr_addr  <= req_addr;
                dr_wdata <= req_wdata;
                dr_be    <= req_be;
                lat_cnt  <= LAT_W'(1);
            end else if (serve_st && lat_cnt != {LAT_W{1'b1}}) begin
                lat_cnt <= lat_cnt + LAT_W'(1);
            end
            if (dr_done_pulse) begin
                dr_done  <= 1'b1;
                dr_rdata <= be_rdata;
            end
            if (do_claim) begin
                dr_valid <= 1'b0;
                rdata_q  <= cmd_is_np_write(dr_cmd) ? '0 : dr_rdata;
            end else if (discard_expire) begin
                dr_valid  <= 1'b0;
                discard_q <= 1'b1;
            end
            if (do_push) begin
                rdata_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        rsp_ack      = (state == TS_ACK);
        rsp_retry    = (state == TS_RETRY);
        rsp_rdata    = rdata_q;
        discard_flag = discard_q;
    end

    dtc_post_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (POST_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_data ({req_addr, req_wdata, req_be}),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    dtc_backend_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (POST_DEPTH)
    ) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_empty    (fifo_empty),
        .fifo_count    (fifo_count),
        .head_addr     (fifo_head[ENTRY_W-1 -: ADDR_W]),
        .head_data     (fifo_head[BE_W +: DATA_W]),
        .head_be       (fifo_head[BE_W-1:0]),
        .dr_latch      (do_latch),
        .dr_valid      (dr_valid),
        .dr_is_write   (cmd_is_np_write(dr_cmd)),
        .dr_addr       (dr_addr),
        .dr_wdata      (dr_wdata),
        .dr_be         (dr_be),
        .be_ack        (be_ack),
        .fifo_pop      (fifo_pop),
        .dr_done_pulse (dr_done_pulse),
        .dr_issue      (dr_issue),
        .ahead_zero    (ahead_zero),
        .be_req        (be_req),
        .be_we         (be_we),
        .be_addr       (be_addr),
        .be_wdata      (be_wdata),
        .be_be         (be_be)
    );

    dtc_claim_timer #(
        .LIMIT (DISCARD_CYCLES)
    ) u_claim (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (dr_valid && dr_done && !serve_st),
        .expire (discard_expire)
    );

endmodule

// File: rtl/dtc_target_chk.sv
`timescale 1ns/1ps
module dtc_target_chk #(
    parameter int ADDR_W = 32,
    parameter int LAT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_delay_en,
    input logic              rsp_retry,
    input logic              be_req,
    input logic              be_ack,
    input logic              be_we,
    input logic [ADDR_W-1:0] be_addr,
    input logic              discard_flag,
    input logic              fifo_push,
    input logic              fifo_full,
    input logic              serve_st,
    input logic [LAT_W-1:0]  lat_cnt,
    input logic [LAT_W-1:0]  lat_limit,
    input logic              dr_issue,
    input logic              ahead_zero,
    input logic              dr_latch,
    input logic              dr_valid
);

    // R3, R4: the master is never held past the selected limit
    a_r3_lat_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (serve_st && cfg_delay_en) |-> (lat_cnt <= lat_limit));

    a_r12_no_retry_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (serve_st && !cfg_delay_en) |=> !rsp_retry);

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    a_r10_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        dr_issue |-> ahead_zero);

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        discard_flag |=> discard_flag);

    a_r8_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        dr_latch |-> !dr_valid);

    // R5, R7: backend request held stable until acknowledged
    a_r5_be_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ack) |=> (be_req && $stable(be_addr) && $stable(be_we)));

endmodule

bind dtc_target dtc_target_chk #(
    .ADDR_W (ADDR_W),
    .LAT_W  (LAT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_delay_en (cfg_delay_en),
    .rsp_retry    (rsp_retry),
    .be_req       (be_req),
    .be_ack       (be_ack),
    .be_we        (be_we),
    .be_addr      (be_addr),
    .discard_flag (discard_flag),
    .fifo_push    (do_push),
    .fifo_full    (fifo_full),
    .serve_st     (serve_st),
    .lat_cnt      (lat_cnt),
    .lat_limit    (lat_limit),
    .dr_issue     (dr_issue),
    .ahead_zero   (ahead_zero),
    .dr_latch     (do_latch),
    .dr_valid     (dr_valid)
);

// File: tb/test_dtc_target.sv
`timescale 1ns/1ps
module test_dtc_target;

    localparam logic [1:0] RD = 2'b00;
    localparam logic [1:0] WN = 2'b01;
    localparam logic [1:0] WP = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_delay_en = 1'b1;
    logic        cfg_host_bridge = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_ack, rsp_retry;
    logic [31:0] rsp_rdata;
    logic        be_req, be_we;
    logic [31:0] be_addr, be_wdata;
    logic [3:0]  be_be;
    logic        be_ack = 1'b0;
    logic [31:0] be_rdata = '0;
    logic        discard_flag;

    int checks = 0;
    int fails = 0;
    int be_lat = 2;
    int ops_done = 0;

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    dtc_target i_dtc_target (
        .clk(clk), .rst_n(rst_n), .cfg_delay_en(cfg_delay_en), .cfg_host_bridge(cfg_host_bridge),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_ack(rsp_ack), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata),
        .be_req(be_req), .be_we(be_we), .be_addr(be_addr), .be_wdata(be_wdata), .be_be(be_be),
        .be_ack(be_ack), .be_rdata(be_rdata), .discard_flag(discard_flag)
    );

    function automatic logic [31:0] rd_model(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic expect_op(input bit we, input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] b, input string tag);
        exp_t e;
        e.we = we; e.addr = a; e.data = d; e.be = b; e.tag = tag;
        expq.push_back(e);
    endtask

    // kind: 1 ack, 2 retry, 0 none; cyc counts edges from the sampling edge
    task automatic do_req(input logic [1:0] cmd, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] b, output int kind, output int cyc,
                          output logic [31:0] rd);
        req_valid = 1'b1; req_cmd = cmd; req_addr = a; req_wdata = d; req_be = b;
        kind = 0; cyc = 0; rd = '0;
        while (kind == 0 && cyc < 400) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (rsp_ack) begin
                kind = 1;
                rd = rsp_rdata;
            end else if (rsp_retry) begin
                kind = 2;
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    // backend model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (be_req === 1'b1) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R8 unexpected backend op", be_addr, 32'h0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(be_we == e.we && be_addr == e.addr && be_be == e.be &&
                          (!e.we || be_wdata == e.data), e.tag, be_addr, e.addr);
                end
                repeat (be_lat) @(negedge clk);
                be_ack = 1'b1;
                be_rdata = rd_model(be_addr);
                @(negedge clk);
                be_ack = 1'b0;
                ops_done++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int k, c, base;
        logic [31:0] rd;

        repeat (3) @(negedge clk);
        check(!rsp_ack && !rsp_retry && !be_req && !discard_flag, "R1 reset outputs",
              {rsp_ack, rsp_retry, be_req, discard_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_ack && !rsp_retry && !be_req && !discard_flag, "R1 after release",
              {rsp_ack, rsp_retry, be_req, discard_flag}, 0);

        // R2 fast read
        be_lat = 2;
        expect_op(0, 32'h100, 0, 4'hF, "R2 backend read");
        do_req(RD, 32'h100, 0, 4'hF, k, c, rd);
        check(k == 1, "R2 ack kind", k, 1);
        check(c <= 16, "R2 latency", c, 16);
        check(rd == rd_model(32'h100), "R2 read data", rd, rd_model(32'h100));

        // R3 retry on edge 16, R6 early reissue, R5 completion
        be_lat = 40;
        expect_op(0, 32'h200, 0, 4'hF, "R3 backend read");
        do_req(RD, 32'h200, 0, 4'hF, k, c, rd);
        check(k == 2 && c == 16, "R3 retry edge", c, 16);
        do_req(RD, 32'h200, 0, 4'hF, k, c, rd);
        check(k == 2 && c == 1, "R6 early reissue retried", k, 2);
        base = ops_done;
        repeat (60) @(negedge clk);
        check(ops_done == base + 1, "R5 backend ran alone", ops_done, base + 1);
        do_req(RD, 32'h200, 0, 4'hF, k, c, rd);
        check(k == 1 && c == 1, "R5 reissue acked at once", c, 1);
        check(rd == rd_model(32'h200), "R5 read data", rd, rd_model(32'h200));

        // R4 host bridge limit
        cfg_host_bridge = 1'b1;
        be_lat = 50;
        expect_op(0, 32'h300, 0, 4'hF, "R4 backend read");
        do_req(RD, 32'h300, 0, 4'hF, k, c, rd);
        check(k == 2 && c == 32, "R4 retry edge", c, 32);
        repeat (80) @(negedge clk);
        do_req(RD, 32'h300, 0, 4'hF, k, c, rd);
        check(k == 1 && rd == rd_model(32'h300), "R4 claim", rd, rd_model(32'h300));
        cfg_host_bridge = 1'b0;

        // R7 delayed non-posted write
        be_lat = 40;
        expect_op(1, 32'h400, 32'hCAFE_0001, 4'b0011, "R7 backend write");
        do_req(WN, 32'h400, 32'hCAFE_0001, 4'b0011, k, c, rd);
        check(k == 2 && c == 16, "R7 write retried", c, 16);
        repeat (60) @(negedge clk);
        do_req(WN, 32'h400, 32'hCAFE_0001, 4'b0011, k, c, rd);
        check(k == 1 && c == 1, "R7 completion acked", k, 1);
        check(rd == 32'h0, "R7 completion data zero", rd, 0);

        // R8 single slot, mismatch retried and not latched
        expect_op(0, 32'h500, 0, 4'hF, "R8 backend read");
        base = ops_done;
        do_req(RD, 32'h500, 0, 4'hF, k, c, rd);
        check(k == 2, "R8 first retry", k, 2);
        do_req(RD, 32'h504, 0, 4'hF, k, c, rd);
        check(k == 2 && c == 1, "R8 address mismatch retried", k, 2);
        do_req(RD, 32'h500, 0, 4'b0001, k, c, rd);
        check(k == 2 && c == 1, "R8 byte enable mismatch retried", k, 2);
        do_req(WN, 32'h500, 0, 4'hF, k, c, rd);
        check(k == 2 && c == 1, "R8 command mismatch retried", k, 2);
        repeat (60) @(negedge clk);
        check(ops_done == base + 1, "R8 one backend op", ops_done, base + 1);
        do_req(RD, 32'h500, 0, 4'hF, k, c, rd);
        check(k == 1 && rd == rd_model(32'h500), "R8 original claimed", rd, rd_model(32'h500));

        // R9 and R10 ordering of posted writes around a delayed read
        be_lat = 20;
        base = ops_done;
        for (int i = 0; i < 3; i++) begin
            expect_op(1, 32'h600 + 32'(4 * i), 32'h1000 + 32'(i), 4'hF, "R10 post before read");
            do_req(WP, 32'h600 + 32'(4 * i), 32'h1000 + 32'(i), 4'hF, k, c, rd);
            check(k == 1 && c == 1, "R9 post acked", c, 1);
        end
        expect_op(0, 32'h700, 0, 4'hF, "R10 read after posts");
        do_req(RD, 32'h700, 0, 4'hF, k, c, rd);
        check(k == 2 && c == 16, "R10 read retried", c, 16);
        expect_op(1, 32'h610, 32'h2000, 4'hF, "R10 post after read");
        do_req(WP, 32'h610, 32'h2000, 4'hF, k, c, rd);
        check(k == 1 && c == 1, "R9 post acked while pending", c, 1);
        k = 0;
        for (int t = 0; t < 40 && k != 1; t++) begin
            repeat (5) @(negedge clk);
            do_req(RD, 32'h700, 0, 4'hF, k, c, rd);
        end
        check(k == 1 && rd == rd_model(32'h700), "R10 read completed", rd, rd_model(32'h700));
        check(ops_done >= base + 4, "R10 posts drained first", ops_done, base + 4);
        repeat (60) @(negedge clk);
        check(expq.size() == 0, "R10 all backend ops seen", expq.size(), 0);

        // R9 full queue
        be_lat = 30;
        for (int i = 0; i < 4; i++) begin
            expect_op(1, 32'h800 + 32'(4 * i), 32'h3000 + 32'(i), 4'hF, "R9 queued post");
            do_req(WP, 32'h800 + 32'(4 * i), 32'h3000 + 32'(i), 4'hF, k, c, rd);
            check(k == 1, "R9 post accepted", k, 1);
        end
        do_req(WP, 32'h840, 32'h3999, 4'hF, k, c, rd);
        check(k == 2 && c == 1, "R9 full queue retried", k, 2);
        repeat (200) @(negedge clk);
        check(expq.size() == 0, "R9 queue drained exactly", expq.size(), 0);

        // R12 delayed mode off
        cfg_delay_en = 1'b0;
        be_lat = 40;
        expect_op(0, 32'h900, 0, 4'hF, "R12 backend read");
        do_req(RD, 32'h900, 0, 4'hF, k, c, rd);
        check(k == 1, "R12 no retry", k, 1);
        check(c > 16, "R12 waited in place", c, 17);
        check(rd == rd_model(32'h900), "R12 read data", rd, rd_model(32'h900));
        cfg_delay_en = 1'b1;

        // R11 discard of an unclaimed completion
        expect_op(0, 32'hA00, 0, 4'hF, "R11 backend read");
        do_req(RD, 32'hA00, 0, 4'hF, k, c, rd);
        check(k == 2, "R11 first retry", k, 2);
        repeat (100) @(negedge clk);
        check(!discard_flag, "R11 flag low before timeout", discard_flag, 0);
        repeat (32768) @(negedge clk);
        check(discard_flag, "R11 flag set", discard_flag, 1);
        be_lat = 2;
        expect_op(0, 32'hA00, 0, 4'hF, "R11 reissue is new request");
        do_req(RD, 32'hA00, 0, 4'hF, k, c, rd);
        check(k == 1 && rd == rd_model(32'hA00), "R11 fresh read", rd, rd_model(32'hA00));
        repeat (5) @(negedge clk);
        check(discard_flag && expq.size() == 0, "R11 flag sticky", discard_flag, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule